// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a synchronous request port inside a chip to an external asynchronous static RAM of 262,144 sixteen-bit words. It accepts one request at a time through a valid/ready handshake. A request carries an address, a write flag, a two-bit lane mask and write data. The controller then drives the RAM's active-low chip, write, output and byte-lane strobes through a fixed sequence of clocked phases. The phase lengths are worked out at compile time from the clock period and the RAM's access time.

The controller never drives the bidirectional data bus directly. It produces a drive enable and a data word, and the top level builds the tristate pad from them. Read data comes back on a one-cycle response pulse. Whenever no access is in progress, the chip strobe is held inactive so the RAM stays in standby.

Top module: `async_sram_ctl`

## Requirements
- R1: While reset is asserted and afterwards until the first request, `sram_ce_n`, `sram_we_n`, `sram_oe_n`, `sram_lb_n` and `sram_ub_n` are 1, `sram_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_ready` is 1 only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 in the cycle that follows.
- R3: A write runs through three phases. First, one setup cycle: chip strobe low, write strobe high, data driven. Next, the write strobe is low for STROBE cycles. Last, one hold cycle with the write strobe high again while address and data are unchanged and still driven. The controller is idle in the cycle after the hold cycle.
- R4: A read runs through two phases. First, one setup cycle: chip strobe low, output strobe high. Next, the output strobe is low for STROBE cycles. The write strobe stays high and the data drive enable stays 0 throughout.
- R5: `rsp_valid` is 1 for exactly one cycle, the cycle right after the last output-strobe cycle. `rsp_rdata` then holds the bus value sampled on the closing edge of that strobe phase.
- R6: Lane mask bit 0 selects data bits 7:0 and drives `sram_lb_n` low. Mask bit 1 selects bits 15:8 and drives `sram_ub_n` low. This holds for every cycle of the access. A write changes only the selected lanes of the RAM word.
- R7: On a read, lanes whose mask bit is 0 return zero in `rsp_rdata`, whatever the bus carries on them.
- R8: A read ends with one turnaround cycle in which the chip and output strobes are high and the data drive enable is 0. This cycle comes before the controller is ready again.
- R9: The data drive enable is never 1 while the output strobe is low, and the write and output strobes are never low together.
- R10: Whenever `req_ready` is 1, `sram_ce_n` is 1, so the RAM is in standby.
- R11: STROBE equals the strobe time parameter divided by the clock period parameter, rounded up, with a minimum of 1. With a 5 ns clock and a 10 ns strobe time it is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_mask | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | 18 | RAM address |
| sram_ce_n | output | 1 | Chip strobe, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output strobe, active low |
| sram_lb_n | output | 1 | Low-byte lane strobe, active low |
| sram_ub_n | output | 1 | High-byte lane strobe, active low |
| sram_dq_out | output | 16 | Data to drive onto the bus |
| sram_dq_oe | output | 1 | Drive enable for the data pad |
| sram_dq_in | input | 16 | Data sampled from the bus |

## Verification
The bench pairs a read with a write that follows at once, which targets the turnaround. A controller that skipped it, or that enabled its drivers during the output strobe, would be caught by the bus-contention monitor in the RAM model. Partial-lane writes over a known word expose a lane-strobe inversion or swap, because the wrong byte would change. Partial-lane reads over a model that puts junk on undriven lanes expose missing zero masking. The phase-by-phase checks run with a two-cycle strobe. A controller that released the write strobe a cycle early, dropped the hold cycle, or raised the response at the wrong time would show up as a mismatch on a specific cycle.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_SETUP  = 3'd1,
        S_STROBE = 3'd2,
        S_WHOLD  = 3'd3,
        S_TURN   = 3'd4
    } ctl_state_e;

    // Strobe levels and drive enable produced for one phase.
    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic lanes_on;
        logic dq_oe;
    } sram_pins_t;

    // Clock cycles needed to cover t_ps at clk_ps, rounded up, at least one.
    function automatic int wait_cycles(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
`timescale 1ns/1ps
module sram_wait_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W      = 2,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             is_write,
    input  logic             phase_done,
    output ctl_state_e       state,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);
    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);

    ctl_state_e nxt;

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        case (state)
            S_IDLE: if (accept) begin
                nxt      = S_SETUP;
                load     = 1'b1;
                load_val = SETUP_LD;
            end
            S_SETUP: if (phase_done) begin
                nxt      = S_STROBE;
                load     = 1'b1;
                load_val = STROBE_LD;
            end
            S_STROBE: if (phase_done)
                nxt = is_write ? S_WHOLD : S_TURN;
            S_WHOLD: nxt = S_IDLE;
            S_TURN:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/sram_pin_decode.sv
`timescale 1ns/1ps
module sram_pin_decode
    import sram_ctl_pkg::*;
(
    input  ctl_state_e state,
    input  logic       is_write,
    output sram_pins_t pins
);
    always_comb begin
        pins = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, lanes_on: 1'b0, dq_oe: 1'b0};
        case (state)
            S_SETUP: begin
                pins.ce_n     = 1'b0;
                pins.lanes_on = 1'b1;
                pins.dq_oe    = is_write;
            end
            S_STROBE: begin
                pins.ce_n     = 1'b0;
                pins.lanes_on = 1'b1;
                pins.we_n     = !is_write;
                pins.oe_n     = is_write;
                pins.dq_oe    = is_write;
            end
            S_WHOLD: begin
                pins.ce_n     = 1'b0;
                pins.lanes_on = 1'b1;
                pins.dq_oe    = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/async_sram_ctl.sv
`timescale 1ns/1ps
module async_sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int CLK_PS    = 10000,
    parameter int STROBE_PS = 10000,
    parameter int SETUP_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_mask,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic              sram_lb_n,
    output logic              sram_ub_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int LANES      = 2;
    localparam int LANE_W     = DATA_W / LANES;
    localparam int STROBE_CYC = wait_cycles(STROBE_PS, CLK_PS);
    localparam int MAX_CYC    = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int CNT_W      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    typedef struct packed {
        logic              write;
        logic [LANES-1:0]  mask;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    req_t              req_q;
    ctl_state_e        state;
    sram_pins_t        pins;
    logic              accept, load, phase_done;
    logic [CNT_W-1:0]  load_val;
    logic [DATA_W-1:0] lane_bits;
    logic [DATA_W-1:0] rdata_q;

    assign req_ready = (state == S_IDLE);
    assign accept    = req_valid && req_ready;

    sram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .done(phase_done)
    );

    sram_ctl_fsm #(.CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC)) u_fsm (
        .clk(clk), .rst(rst), .accept(accept), .is_write(req_q.write),
        .phase_done(phase_done), .state(state), .load(load), .load_val(load_val)
    );

    sram_pin_decode u_dec (.state(state), .is_write(req_q.write), .pins(pins));

    // Captured request stays put for the whole access.
    always_ff @(posedge clk) begin
        if (rst)
            req_q <= '0;
        else if (accept)
            req_q <= '{write: req_write, mask: req_mask, addr: req_addr, wdata: req_wdata};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bits[g*LANE_W +: LANE_W] = {LANE_W{req_q.mask[g]}};
    end

    // Sample the bus on the edge that closes the output-strobe phase.
    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (state == S_STROBE && !req_q.write && phase_done)
            rdata_q <= sram_dq_in & lane_bits;
    end

    assign rsp_valid   = (state == S_TURN);
    assign rsp_rdata   = rdata_q;
    assign sram_addr   = req_q.addr;
    assign sram_dq_out = req_q.wdata;
    assign sram_ce_n   = pins.ce_n;
    assign sram_we_n   = pins.we_n;
    assign sram_oe_n   = pins.oe_n;
    assign sram_dq_oe  = pins.dq_oe;
    assign sram_lb_n   = pins.lanes_on ? !req_q.mask[0] : 1'b1;
    assign sram_ub_n   = pins.lanes_on ? !req_q.mask[1] : 1'b1;
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic [DATA_W-1:0] sram_dq_out,
    input logic              sram_dq_oe
);
    a_r2_busy_after_take: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r3_hold_on_we_rise: assert property (@(posedge clk) disable iff (rst)
        ($rose(sram_we_n) && !sram_ce_n) |-> (sram_dq_oe && $stable(sram_addr) && $stable(sram_dq_out)));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r8_turnaround: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (sram_ce_n && sram_oe_n && !sram_dq_oe));

    a_r9_no_drive_under_oe: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> sram_oe_n);

    a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!sram_we_n && !sram_oe_n));

    a_r10_standby_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> sram_ce_n);
endmodule

bind async_sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_async_sram_ctl.sv
`timescale 1ns/1ps
module sim_async_sram_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_mask = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n;
    logic [15:0] sram_dq_out;
    logic        sram_dq_oe;
    logic [15:0] sram_dq_in;

    int tests = 0;
    int fails = 0;
    int bus_errs = 0;
    bit finished = 1'b0;

    always #2.5 clk = !clk;

    // 5 ns clock, 10 ns strobe: two strobe cycles (R11).
    async_sram_ctl #(.CLK_PS(5000), .STROBE_PS(10000), .SETUP_CYC(1)) u0 (.*);

    // Behavioural RAM: undriven lanes carry junk.
    logic [15:0] mem    [0:1023];
    logic [15:0] shadow [0:1023];
    logic lo_drv, hi_drv;
    logic [15:0] rd_word;

    initial for (int i = 0; i < 1024; i++) begin
        mem[i] = 16'h0;
        shadow[i] = 16'h0;
    end

    always_comb begin
        lo_drv  = !sram_ce_n && !sram_oe_n && sram_we_n && !sram_lb_n;
        hi_drv  = !sram_ce_n && !sram_oe_n && sram_we_n && !sram_ub_n;
        rd_word = mem[sram_addr[9:0]];
        sram_dq_in = {hi_drv ? rd_word[15:8] : 8'hA5, lo_drv ? rd_word[7:0] : 8'h5A};
    end

    always @(posedge sram_we_n) begin
        if (!rst && !sram_ce_n) begin
            if (!sram_dq_oe) bus_errs++;
            if (!sram_lb_n) mem[sram_addr[9:0]][7:0]  <= sram_dq_out[7:0];
            if (!sram_ub_n) mem[sram_addr[9:0]][15:8] <= sram_dq_out[15:8];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (sram_dq_oe && (lo_drv || hi_drv)) bus_errs++;
            if (!sram_we_n && !sram_oe_n) bus_errs++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input logic [17:0] a, input logic [1:0] m, input logic [15:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_mask = m; req_wdata = d;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [17:0] a, input logic [1:0] m, input logic [15:0] d);
        logic [4:0] p;
        issue(1'b1, a, m, d);
        @(negedge clk); // setup
        p = {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready};
        chk(p == 5'b01110 && sram_addr == a && sram_dq_out == d, "R3 setup", {27'd0, p}, 32'b01110);
        chk({sram_ub_n, sram_lb_n} == ~m, "R6 lanes", {30'd0, sram_ub_n, sram_lb_n}, {30'd0, ~m});
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); // strobe
            p = {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready};
            chk(p == 5'b00110, "R3 strobe", {27'd0, p}, 32'b00110);
        end
        @(negedge clk); // hold
        p = {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, req_ready};
        chk(p == 5'b01110 && sram_addr == a && sram_dq_out == d, "R3 hold", {27'd0, p}, 32'b01110);
        @(negedge clk); // idle
        chk(req_ready && sram_ce_n && !sram_dq_oe, "R10 idle after write", {31'd0, req_ready}, 32'd1);
        if (m[0]) shadow[a[9:0]][7:0]  = d[7:0];
        if (m[1]) shadow[a[9:0]][15:8] = d[15:8];
    endtask

    task automatic do_read(input logic [17:0] a, input logic [1:0] m);
        logic [15:0] exp;
        logic [4:0] p;
        exp = shadow[a[9:0]] & {{8{m[1]}}, {8{m[0]}}};
        issue(1'b0, a, m, 16'h0);
        @(negedge clk);
        p = {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, rsp_valid};
        chk(p == 5'b01100, "R4 setup", {27'd0, p}, 32'b01100);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            p = {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, rsp_valid};
            chk(p == 5'b01000, "R4 strobe", {27'd0, p}, 32'b01000);
        end
        @(negedge clk); // turnaround
        chk(rsp_valid && rsp_rdata == exp, "R5/R7 data", {15'd0, rsp_valid, rsp_rdata}, {15'd0, 1'b1, exp});
        chk(sram_ce_n && sram_oe_n && !sram_dq_oe && !req_ready, "R8 turn", {28'd0, sram_ce_n, sram_oe_n, sram_dq_oe, req_ready}, 32'b1100);
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R5 single pulse", {30'd0, rsp_valid, req_ready}, 32'b01);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(sram_ce_n && sram_we_n && sram_oe_n && sram_lb_n && sram_ub_n && !sram_dq_oe && req_ready && !rsp_valid,
            "R1 reset", {26'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe}, 32'b111110);
    endtask

    task automatic t_full_word();
        do_write(18'h00010, 2'b11, 16'hBEEF);
        do_read(18'h00010, 2'b11);
    endtask

    task automatic t_lane_writes();   // R6
        do_write(18'h00020, 2'b11, 16'h1234);
        do_write(18'h00020, 2'b01, 16'hABCD);
        do_read(18'h00020, 2'b11);     // expect 12CD
        do_write(18'h00020, 2'b10, 16'h9900);
        do_read(18'h00020, 2'b11);     // expect 99CD
    endtask

    task automatic t_lane_reads();    // R7
        do_write(18'h00030, 2'b11, 16'hC3E1);
        do_read(18'h00030, 2'b01);
        do_read(18'h00030, 2'b10);
    endtask

    task automatic t_turnaround();    // R8, R9: read followed at once by write
        do_write(18'h00040, 2'b11, 16'h5555);
        do_read(18'h00040, 2'b11);
        do_write(18'h00041, 2'b11, 16'hAAAA);
        do_read(18'h00041, 2'b11);
        chk(bus_errs == 0, "R9 bus contention", bus_errs, 0);
    endtask

    task automatic t_standby();       // R10
        bit ok = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!sram_ce_n || !req_ready) ok = 1'b0;
        end
        chk(ok, "R10 standby", {31'd0, ok}, 32'd1);
    endtask

    task automatic t_high_addr();
        do_write(18'h3FFFF, 2'b11, 16'h0F0F);
        do_read(18'h3FFFF, 2'b11);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();                    // R1 under reset
        #1 rst = 1'b0;
        t_reset();                    // R1 after release
        t_full_word();                // R2, R3, R4, R5
        t_lane_writes();
        t_lane_reads();
        t_turnaround();
        t_standby();
        t_high_addr();                // R11 timing checked in every phase
        chk(bus_errs == 0, "R9 final", bus_errs, 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule